// File: doc/BRIEF.md
# Strobed Parallel Output Port

This block is a byte-wide, output-only parallel port. It presents a register interface to the rest of the chip: a one-cycle write enable with write data, and a read-data bus. Every accepted write stores the byte in a holding register, and that register drives the output pins directly. A read always returns the stored byte. The pins are never sampled back, and there is no direction control.

A mode input picks one of two behaviours. When the handshake-select input is 0, the port runs in simple strobed mode, and each write also raises a strobe on a separate pin. The strobe stays asserted for a fixed number of clock cycles, two by default. A polarity input sets whether the asserted strobe level is high or low. When the handshake-select input is 1, writes update the data but start no strobe. Handshake sequencing for that mode belongs to logic outside this block.

Top module: `strobed_out_port`

## Requirements
- R1: A cycle with `wr_en` high loads `wr_data` into the port, and `pins_out` shows the new byte from the clock edge that samples the write.
- R2: `rd_data` always equals the last byte written (0x00 after reset), whatever the strobe is doing.
- R3: In a cycle without `wr_en`, `pins_out` keeps its previous value.
- R4: With `hs_sel` = 0, a write makes the strobe assert for exactly 2 clock cycles (PULSE_CYCLES), starting at the edge that samples the write. The strobe is then deasserted.
- R5: With `hs_sel` = 1, a write starts no strobe, and the data is still latched as in R1.
- R6: With `strb_pol` = 1 the strobe is asserted high and idles low. With `strb_pol` = 0 it is asserted low and idles high. The level follows `strb_pol` in the same cycle.
- R7: A simple-mode write that arrives while a strobe is asserted restarts the count, so the strobe stays asserted for 2 full cycles after that write.
- R8: While `rst` is high at a clock edge, the port clears to 0x00 and the strobe goes to its idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe from the register interface |
| wr_data | input | 8 | Byte to write |
| hs_sel | input | 1 | 0 = simple strobed mode, 1 = no strobe on write |
| strb_pol | input | 1 | 1 = strobe asserted high, 0 = asserted low |
| rd_data | output | 8 | Last byte written |
| pins_out | output | 8 | Byte driven to the port pins |
| strobe_out | output | 1 | Strobe pin |

## Verification
The hardest case to reach is a write that lands inside a strobe that is already asserted: on the first or the last asserted cycle, or while the mode or polarity input is changing. That case is the only one that shows whether the count restarts or stretches. The stimulus first sends back-to-back writes and writes spaced one and two cycles apart. It then runs a long random phase that toggles the write, mode and polarity inputs independently, so that a write falls on every position in the pulse. The bench model tracks the remaining pulse length as an integer, and the outputs are compared against it on every cycle.

// File: rtl/strobed_out_port_pkg.sv
package strobed_out_port_pkg;
  typedef enum logic {
    MODE_SIMPLE = 1'b0,
    MODE_FULL   = 1'b1
  } strobe_mode_e;

  function automatic logic strobe_level(input logic asserted, input logic pol);
    return pol ? asserted : ~asserted;
  endfunction
endpackage

// File: rtl/spo_data_reg.sv
module spo_data_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(din));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/spo_pulse_timer.sv
module spo_pulse_timer #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)              remain <= '0;
    else if (fire)        remain <= LOAD;
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign active = (remain != '0);

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    fire |=> remain == LOAD);
  assert_countdown_R4: assert property (@(posedge clk) disable iff (rst)
    (!fire && remain != '0) |=> remain == $past(remain) - 1'b1);
  assert_bound_R4: assert property (@(posedge clk) disable iff (rst)
    remain <= LOAD);
endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port
  import strobed_out_port_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hs_sel,
  input  logic              strb_pol,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pins_out,
  output logic              strobe_out
);
  strobe_mode_e mode;
  logic         fire;
  logic         pulse_on;
  logic [DATA_W-1:0] port_q;

  assign mode = strobe_mode_e'(hs_sel);
  assign fire = wr_en && (mode == MODE_SIMPLE);

  spo_data_reg #(.W(DATA_W)) u_data (
    .clk (clk),
    .rst (rst),
    .load(wr_en),
    .din (wr_data),
    .q   (port_q)
  );

  spo_pulse_timer #(.LEN(PULSE_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .active(pulse_on)
  );

  assign pins_out   = port_q;
  assign rd_data    = port_q;
  assign strobe_out = strobe_level(pulse_on, strb_pol);

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (pins_out == '0) && !pulse_on);
  assert_nostrobe_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hs_sel && !pulse_on) |=> !pulse_on);
  assert_start_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hs_sel) |=> pulse_on);
endmodule

// File: tb/test_strobed_out_port.sv
module test_strobed_out_port;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 2;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst, wr_en, hs_sel, strb_pol;
  logic [7:0] wr_data, rd_data, pins_out;
  logic strobe_out;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  string cur_req = "R8";

  // reference model state
  int m_data = 0;
  int m_left = 0;

  strobed_out_port i_strobed_out_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .hs_sel(hs_sel), .strb_pol(strb_pol), .rd_data(rd_data),
    .pins_out(pins_out), .strobe_out(strobe_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_data = 0;
      m_left = 0;
    end else begin
      if (wr_en) m_data = wr_data;
      if (wr_en && !hs_sel) m_left = LEN;
      else if (m_left > 0) m_left = m_left - 1;
    end
  end

  task automatic compare(string req);
    logic exp_s;
    exp_s = (m_left > 0) ? strb_pol : ~strb_pol;
    n_checks++;
    if (pins_out !== 8'(m_data)) begin
      n_fail++;
      $display("FAIL %s pins_out actual=%h expected=%h", req, pins_out, 8'(m_data));
    end
    n_checks++;
    if (rd_data !== 8'(m_data)) begin
      n_fail++;
      $display("FAIL R2 rd_data actual=%h expected=%h", rd_data, 8'(m_data));
    end
    n_checks++;
    if (strobe_out !== exp_s) begin
      n_fail++;
      $display("FAIL %s strobe_out actual=%b expected=%b", req, strobe_out, exp_s);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cycles > 0) compare(cur_req);
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; hs_sel = 1'b0; strb_pol = 1'b1;
    cur_req = "R8";
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1 / R3 / R4: single writes, active-high strobe
    cur_req = "R4";
    wr(8'hA5); idle(4);
    wr(8'h3C); idle(1); wr(8'hC3); idle(5);

    // R7: write on each asserted cycle of a pulse
    cur_req = "R7";
    wr(8'h11); wr(8'h22); idle(1); wr(8'h33); idle(1); wr(8'h44); idle(4);

    // R5: full mode, writes latch but no strobe
    cur_req = "R5";
    hs_sel = 1'b1;
    wr(8'h55); idle(3); wr(8'h66); wr(8'h77); idle(3);

    // R6: active-low polarity, and a live polarity flip mid-pulse
    cur_req = "R6";
    hs_sel = 1'b0; strb_pol = 1'b0;
    wr(8'h88); idle(4);
    wr(8'h99); idle(1); strb_pol = 1'b1; idle(4);

    // R8: reset in the middle of a pulse
    cur_req = "R8";
    wr(8'hEE);
    @(negedge clk); wr_en = 1'b0; rst = 1'b1;
    idle(2); rst = 1'b0; idle(2);

    // R1/R3/R4/R5/R6/R7 mixed random
    cur_req = "R7";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      wr_en    = ($urandom % 3) == 0;
      wr_data  = 8'($urandom);
      if (($urandom % 16) == 0) hs_sel = ~hs_sel;
      if (($urandom % 20) == 0) strb_pol = ~strb_pol;
    end
    idle(5);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule